// File: doc/BRIEF.md
# Eight-Pin Sampled Interrupt Sense Controller

This block sits between eight external request pins and an interrupt controller. Each pin is brought into the system clock domain through two flip-flops. After that, each pin is evaluated in one of four sense modes that software selects: active-low level, any change, falling edge or rising edge. Edge and change events are held in a sticky pending flag. In level mode the request tracks the pin directly and nothing is stored. A pin reaches the request output only when its mask bit and the global interrupt enable are both set. The outputs are one request line and the index of the winning pin. The lowest pin number has the highest priority.

Software uses a small register port with four word addresses. Address 0 holds the sense modes of pins 0 to 3 and address 1 holds those of pins 4 to 7. Address 2 is the mask. Address 3 is the pending view. Writing 1 to a bit of the pending view clears that pin's flag, and an acknowledge strobe with a pin index does the same. Rewriting a mode field while its mask bit is set can raise an unwanted request. The block does nothing to prevent this, so software clears the mask before it changes a mode.

Top module: `xint_ctrl`

## Requirements
- R1: Sense modes are 2-bit fields with the encoding 00 = low level, 01 = any change, 10 = falling edge, 11 = rising edge. Address 0 holds pin k (k = 0..3) in bits 2k+1:2k, and address 1 holds pin k+4 in the same bits. Address 2 is the mask, with bit k for pin k. All mode and mask bits read back 0 after reset.
- R2: Each pin passes through two synchronizing flops. A level request shows at `irq_o` after the second rising clock edge that follows a pin change, and not after the first. An edge flag shows in the pending view after the third edge and not after the second.
- R3: In low-level mode, pending bit k and the request follow the synchronized pin. They are set while the pin is low and drop two edges after it returns high. Writing 1 to that pending bit does not clear a pin that is still low.
- R4: Any-change mode sets the flag on both a falling and a rising transition of the pin.
- R5: Falling mode sets the flag on a high-to-low transition only.
- R6: Rising mode sets the flag on a low-to-high transition only.
- R7: A pulse that lasts one clock period sets the flag.
- R8: A flag is set even while its mask bit is 0, and it can be seen in the pending view (address 3). `irq_o` is 1 only for a pin whose mask bit is set, and only while `gie_i` is 1.
- R9: A flag stays set until one of two things happens: a write to address 3 with a 1 in its bit, or `ack_i` with `ack_idx_i` equal to its pin number. Writing 0 bits has no effect.
- R10: `irq_idx_o` gives the lowest-numbered pin that is both active and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| pin_i | input | 8 | External request pins, asynchronous |
| gie_i | input | 1 | Global interrupt enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| ack_i | input | 1 | Acknowledge strobe that clears one flag |
| ack_idx_i | input | 3 | Pin index being acknowledged |
| irq_o | output | 1 | Combined interrupt request |
| irq_idx_o | output | 3 | Index of the highest-priority requesting pin |

## Verification
A table sets pins 0 to 3 to the four sense modes and drives single-pin falls and rises, then several pins changing together. The single-pin steps show which modes respond to which transition direction. The combined steps show the priority choice when more than one pin is pending. Directed tests use a one-cycle pulse, a masked event that is unmasked later, toggling of `gie_i`, and write-1 and write-0 clears against acknowledge. Sampling on each clock edge after a pin change confirms the two-stage and three-stage latency. Holding a level pin low while clearing it shows that the level request is not latched.

// File: rtl/xint_pkg.sv
package xint_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    localparam int unsigned MODE_BITS    = 2;
    localparam int unsigned REG_W        = 8;
    localparam int unsigned PINS_PER_REG = REG_W / MODE_BITS;

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
    parameter int unsigned N_PINS = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] cur_o,
    output logic [N_PINS-1:0] prev_o
);

    typedef struct packed {
        logic [N_PINS-1:0] meta;
        logic [N_PINS-1:0] cur;
        logic [N_PINS-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_i;
        st_d.cur  = st_q.meta;
        st_d.prev = st_q.cur;
    end

    // idle level of the pins is high, so the chain starts at ones
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '1;
        else         st_q <= st_d;
    end

    assign cur_o  = st_q.cur;
    assign prev_o = st_q.prev;

    AST_PREV_LAGS_CUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prev_o == $past(cur_o)) else $error("prev sample does not lag current"); // R2

endmodule

// File: rtl/xint_detect.sv
module xint_detect
    import xint_pkg::*;
#(
    parameter int unsigned N_PINS = 8
) (
    input  logic [N_PINS*MODE_BITS-1:0] mode_i,
    input  logic [N_PINS-1:0]           cur_i,
    input  logic [N_PINS-1:0]           prev_i,
    output logic [N_PINS-1:0]           event_o,
    output logic [N_PINS-1:0]           lvl_mode_o,
    output logic [N_PINS-1:0]           low_req_o
);

    function automatic logic sense_event(input sense_e m, input logic c, input logic p);
        logic up, dn;
        up = c & ~p;
        dn = ~c & p;
        unique case (m)
            SENSE_LOW:  sense_event = 1'b0;
            SENSE_ANY:  sense_event = up | dn;
            SENSE_FALL: sense_event = dn;
            SENSE_RISE: sense_event = up;
            default:    sense_event = 1'b0;
        endcase
    endfunction

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        sense_e pin_mode;
        assign pin_mode      = sense_e'(mode_i[i*MODE_BITS +: MODE_BITS]);
        assign event_o[i]    = sense_event(pin_mode, cur_i[i], prev_i[i]);
        assign lvl_mode_o[i] = (pin_mode == SENSE_LOW);
        assign low_req_o[i]  = (pin_mode == SENSE_LOW) & ~cur_i[i];
    end

endmodule

// File: rtl/xint_prio.sv
module xint_prio #(
    parameter int unsigned N_PINS = 8,
    localparam int unsigned IDX_W = $clog2(N_PINS)
) (
    input  logic [N_PINS-1:0] req_i,
    output logic              valid_o,
    output logic [IDX_W-1:0]  idx_o
);

    // scan from the top so the lowest set bit is the last one to write
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = N_PINS - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
    import xint_pkg::*;
#(
    parameter int unsigned N_PINS = 8,
    localparam int unsigned IDX_W     = $clog2(N_PINS),
    localparam int unsigned MODE_W    = N_PINS * MODE_BITS,
    localparam int unsigned MODE_REGS = MODE_W / REG_W,
    localparam int unsigned ADDR_W    = $clog2(MODE_REGS + 2),
    localparam int unsigned MASK_ADDR = MODE_REGS,
    localparam int unsigned PEND_ADDR = MODE_REGS + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_PINS-1:0] pin_i,
    input  logic              gie_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic              ack_i,
    input  logic [IDX_W-1:0]  ack_idx_i,
    output logic              irq_o,
    output logic [IDX_W-1:0]  irq_idx_o
);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [N_PINS-1:0] mask;
        logic [N_PINS-1:0] flags;
    } regs_t;

    regs_t r_d, r_q;

    logic [N_PINS-1:0] cur, prev;
    logic [N_PINS-1:0] edge_evt, lvl_mode, low_req;
    logic [N_PINS-1:0] clr_vec, active, req;

    xint_sync #(.N_PINS(N_PINS)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .cur_o  (cur),
        .prev_o (prev)
    );

    xint_detect #(.N_PINS(N_PINS)) u_detect (
        .mode_i     (r_q.mode),
        .cur_i      (cur),
        .prev_i     (prev),
        .event_o    (edge_evt),
        .lvl_mode_o (lvl_mode),
        .low_req_o  (low_req)
    );

    // flag clear sources: write-one to the pending view, or acknowledge by index
    always_comb begin
        clr_vec = '0;
        if (reg_we_i && reg_addr_i == ADDR_W'(PEND_ADDR))
            clr_vec = reg_wdata_i[N_PINS-1:0];
        if (ack_i)
            clr_vec[ack_idx_i] = 1'b1;
    end

    always_comb begin
        r_d = r_q;
        if (reg_we_i) begin
            for (int r = 0; r < MODE_REGS; r++) begin
                if (reg_addr_i == ADDR_W'(r))
                    r_d.mode[r*REG_W +: REG_W] = reg_wdata_i;
            end
            if (reg_addr_i == ADDR_W'(MASK_ADDR))
                r_d.mask = reg_wdata_i[N_PINS-1:0];
        end
        // a new event wins over a clear in the same cycle; level pins keep no flag
        r_d.flags = ((r_q.flags & ~clr_vec) | edge_evt) & ~lvl_mode;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign active = r_q.flags | low_req;
    assign req    = active & r_q.mask & {N_PINS{gie_i}};

    xint_prio #(.N_PINS(N_PINS)) u_prio (
        .req_i   (req),
        .valid_o (irq_o),
        .idx_o   (irq_idx_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        for (int r = 0; r < MODE_REGS; r++) begin
            if (reg_addr_i == ADDR_W'(r))
                reg_rdata_o = r_q.mode[r*REG_W +: REG_W];
        end
        if (reg_addr_i == ADDR_W'(MASK_ADDR)) reg_rdata_o = REG_W'(r_q.mask);
        if (reg_addr_i == ADDR_W'(PEND_ADDR)) reg_rdata_o = REG_W'(active);
    end

    AST_GIE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gie_i |-> !irq_o) else $error("request with global enable low"); // R8

    AST_WINNER_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (r_q.mask[irq_idx_o] && active[irq_idx_o])) else $error("winner not enabled"); // R8

    for (genvar i = 0; i < N_PINS; i++) begin : g_chk
        sense_e m;
        assign m = sense_e'(r_q.mode[i*MODE_BITS +: MODE_BITS]);

        AST_NO_LOWER_WAITING: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (irq_o && irq_idx_o > IDX_W'(i)) |-> !req[i]) else $error("lower pin skipped"); // R10

        AST_RISE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (m == SENSE_RISE && cur[i] && !prev[i]) |=> r_q.flags[i]) else $error("rise lost"); // R6

        AST_FALL_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (m == SENSE_FALL && !cur[i] && prev[i]) |=> r_q.flags[i]) else $error("fall lost"); // R5

        AST_LEVEL_FOLLOWS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (m == SENSE_LOW && cur[i]) |-> !active[i]) else $error("level latched"); // R3

        AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (m != SENSE_LOW && r_q.flags[i] && !clr_vec[i]) |=> r_q.flags[i]) else $error("flag dropped"); // R9
    end

endmodule

// File: tb/sim_xint_ctrl.sv
`timescale 1ns/1ps
module sim_xint_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pins = 8'hFF;
    logic       gie = 1'b0;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ack = 1'b0;
    logic [2:0] ack_idx = 3'd0;
    logic       irq;
    logic [2:0] irq_idx;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    xint_ctrl u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_i       (pins),
        .gie_i       (gie),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .ack_i       (ack),
        .ack_idx_i   (ack_idx),
        .irq_o       (irq),
        .irq_idx_o   (irq_idx)
    );

    typedef struct packed {
        logic [7:0] pins;
        logic       irq;
        logic [2:0] idx;
        logic [7:0] pend;
        logic [7:0] clr;
    } vec_t;

    // pins 0..3 in modes low, any, fall, rise; mask 0x0F
    localparam vec_t VEC [13] = '{
        '{8'hFF, 1'b0, 3'd0, 8'h00, 8'h00},
        '{8'hFD, 1'b1, 3'd1, 8'h02, 8'h02},  // R4 fall
        '{8'hFF, 1'b1, 3'd1, 8'h02, 8'h02},  // R4 rise
        '{8'hFB, 1'b1, 3'd2, 8'h04, 8'h04},  // R5
        '{8'hFF, 1'b0, 3'd0, 8'h00, 8'h00},  // R5 rise ignored
        '{8'hF7, 1'b0, 3'd0, 8'h00, 8'h00},  // R6 fall ignored
        '{8'hFF, 1'b1, 3'd3, 8'h08, 8'h08},  // R6
        '{8'hFE, 1'b1, 3'd0, 8'h01, 8'h01},  // R3 low
        '{8'hFE, 1'b1, 3'd0, 8'h01, 8'h00},  // R3 not cleared by write
        '{8'hFF, 1'b0, 3'd0, 8'h00, 8'h00},  // R3 released
        '{8'hF0, 1'b1, 3'd0, 8'h07, 8'h07},  // R10
        '{8'hF0, 1'b1, 3'd0, 8'h01, 8'h00},  // R3
        '{8'hFF, 1'b1, 3'd1, 8'h0A, 8'h0A}   // R10
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic do_ack(input logic [2:0] i);
        @(negedge clk);
        ack = 1'b1; ack_idx = i;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);

        // reset state: R1
        check("R1 irq at reset", {7'd0, irq}, 8'h00);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reg reset", v, 8'h00);
        end

        gie = 1'b1;
        wr(2'd0, 8'hE4);
        wr(2'd2, 8'h0F);
        rd(2'd0, v); check("R1 mode lo readback", v, 8'hE4);
        rd(2'd2, v); check("R1 mask readback", v, 8'h0F);

        for (int s = 0; s < 13; s++) begin
            @(negedge clk);
            pins = VEC[s].pins;
            wait_cyc(3);
            check($sformatf("R4/R5/R6/R3 step %0d irq", s), {7'd0, irq}, {7'd0, VEC[s].irq});
            if (VEC[s].irq)
                check($sformatf("R10 step %0d idx", s), {5'd0, irq_idx}, {5'd0, VEC[s].idx});
            rd(2'd3, v);
            check($sformatf("R4/R5/R6/R3 step %0d pend", s), v, VEC[s].pend);
            if (VEC[s].clr != 8'h00) wr(2'd3, VEC[s].clr);
        end

        // upper mode register layout: pin4 low, pin5 any, pin6 fall, pin7 rise
        wr(2'd1, 8'hE4);
        rd(2'd1, v); check("R1 mode hi readback", v, 8'hE4);
        rd(2'd0, v); check("R1 mode lo untouched", v, 8'hE4);
        wr(2'd2, 8'hF0);

        // one-cycle pulse on pin6
        @(negedge clk); pins = 8'hBF;
        @(negedge clk); pins = 8'hFF;
        wait_cyc(4);
        rd(2'd3, v); check("R7 pulse pend", v, 8'h40);
        check("R7 pulse irq", {5'd0, irq_idx, 1'b0} | {7'd0, irq}, {5'd6, 1'b0} | 8'h01);

        do_ack(3'd6);
        rd(2'd3, v); check("R9 ack clears", v, 8'h00);
        check("R9 irq after ack", {7'd0, irq}, 8'h00);

        // masked event still pends
        wr(2'd2, 8'h00);
        @(negedge clk); pins = 8'hBF;
        @(negedge clk); pins = 8'hFF;
        wait_cyc(4);
        check("R8 masked no irq", {7'd0, irq}, 8'h00);
        rd(2'd3, v); check("R8 masked pend", v, 8'h40);
        wr(2'd2, 8'hF0);
        #0.5;
        check("R8 unmask irq", {7'd0, irq}, 8'h01);
        check("R8 unmask idx", {5'd0, irq_idx}, 8'h06);
        gie = 1'b0; #0.5;
        check("R8 gie off", {7'd0, irq}, 8'h00);
        gie = 1'b1; #0.5;

        wr(2'd3, 8'h00);
        rd(2'd3, v); check("R9 zero write no effect", v, 8'h40);
        wr(2'd3, 8'h40);
        rd(2'd3, v); check("R9 w1c clears", v, 8'h00);

        // two pending: pin5 (any) and pin6 (fall)
        @(negedge clk); pins = 8'h9F;
        wait_cyc(4);
        rd(2'd3, v); check("R10 two pend", v, 8'h60);
        check("R10 lower wins", {5'd0, irq_idx}, 8'h05);
        do_ack(3'd5);
        check("R10 next winner", {5'd0, irq_idx}, 8'h06);
        check("R10 still irq", {7'd0, irq}, 8'h01);
        @(negedge clk); pins = 8'hFF;
        wait_cyc(4);
        wr(2'd3, 8'hFF);

        // synchronizer latency
        wr(2'd2, 8'h01);
        @(negedge clk); pins = 8'hFE;
        @(negedge clk); check("R2 level after 1 edge", {7'd0, irq}, 8'h00);
        @(negedge clk); check("R2 level after 2 edges", {7'd0, irq}, 8'h01);
        pins = 8'hFF;
        @(negedge clk); check("R3 held 1 edge", {7'd0, irq}, 8'h01);
        @(negedge clk); check("R3 drop 2 edges", {7'd0, irq}, 8'h00);
        @(negedge clk); pins = 8'hFD;
        @(negedge clk);
        @(negedge clk); rd(2'd3, v); check("R2 edge after 2 edges", v & 8'h02, 8'h00);
        @(negedge clk); rd(2'd3, v); check("R2 edge after 3 edges", v & 8'h02, 8'h02);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule